// File: doc/BRIEF.md
# DMA Channel Priority Arbiter

This block chooses which DMA channel owns a shared bus for its next transaction. Each channel presents a request, a 3-bit priority level (0 is the most urgent, 7 the least) and a flag that decides whether the channel takes part in round-robin sharing. A processor request always takes precedence over any channel. Once a grant is issued it is held for the whole transaction. The owner pulses a done strobe when the transaction ends, and a new choice is made on the following clock edge. When nobody holds the bus, a new choice is made on every edge.

Selection is by strict priority. An optional fairness mode adds a rotating 6-bit slot counter. Each slot favours one of levels 2 to 7, so level 2 gets half of the slots, level 3 a quarter, and so on down the levels. Levels 0 and 1 are never subject to the schedule. The grant output is one-hot over the channels, plus a separate processor grant.

Top module: `dma_prio_arbiter`

## Requirements
- R1: While reset is asserted and after it, with no requests, no channel grant and no processor grant is driven.
- R2: At an arbitration point with `cpu_req` high, the next edge gives `cpu_gnt` and no channel grant.
- R3: An arbitration point is an edge where the bus is idle or `xfer_done` is high. At any other edge the grants do not change.
- R4: With fairness off, the granted channel has the numerically lowest priority level among requesting channels.
- R5: A more urgent channel that starts requesting during a transaction takes the bus at the next arbitration point, ahead of the current owner.
- R6: Among round-robin channels of the selected level, the grant goes to the first requester above the last channel granted at that level, wrapping from the top index to 0. Each level keeps its own pointer.
- R7: A requesting channel of the selected level with `rr_en` low wins over round-robin channels of that level. Among several such channels, the lowest index wins.
- R8: With fairness on, the slot counter starts at 0 after reset. Let t be the number of trailing one bits of the counter. For t < 6, the favoured level is 2+t. If the favoured level has a request, that level is served. Otherwise strict priority applies. The counter increments on each arbitration point with fairness on and no level-0 or level-1 request.
- R9: With fairness on, a level-0 or level-1 request is served by strict priority and does not advance the slot counter.
- R10: At most one grant is active, and a channel is granted only if it was requesting at the arbitration point.
- R11: An arbitration point with no requests leaves the bus idle. A done strobe while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NCH | Per-channel request |
| prio | input | 3*NCH | Per-channel level, channel i in bits [3i+2:3i] |
| rr_en | input | NCH | 1: channel shares its level by round robin |
| cpu_req | input | 1 | Processor bus request |
| fair_en | input | 1 | Enables the slot schedule |
| xfer_done | input | 1 | Current transaction ends this cycle |
| gnt | output | NCH | One-hot channel grant |
| cpu_gnt | output | 1 | Processor grant |

## Verification
The hardest state to reach is the slot schedule favouring a level deeper than 2. The counter must have advanced a known number of times, and every fallback slot must be predicted. The stimulus enables fairness right after a period in which the counter was frozen. It then holds channels at levels 2, 3, 4 and 7 requesting across eight back-to-back done strobes, so that slots favouring levels 3, 4 and an empty level 5 all occur. After that, a level-0 burst shows that the counter holds still while levels 0 and 1 are being served.

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter #(
  parameter int NCH   = 24,
  parameter int SLOTW = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   req,
  input  logic [3*NCH-1:0] prio,
  input  logic [NCH-1:0]   rr_en,
  input  logic             cpu_req,
  input  logic             fair_en,
  input  logic             xfer_done,
  output logic [NCH-1:0]   gnt,
  output logic             cpu_gnt
);
  localparam int IW   = $clog2(NCH);
  localparam int NLVL = 8;

  logic [NCH-1:0]   gnt_q;
  logic             cpu_q;
  logic [SLOTW-1:0] slot_q;
  logic [IW-1:0]    ptr_q [NLVL];

  logic busy, arb, urgent;
  logic [NLVL-1:0] lvl_any;
  logic [2:0] strict_lvl, fav_lvl, sel_lvl;
  logic fav_ok, use_fav;
  logic [NCH-1:0] cand;
  logic [IW-1:0] pick_idx;
  logic pick_ok;

  assign busy    = cpu_q | (|gnt_q);
  assign arb     = !busy || xfer_done;
  assign urgent  = lvl_any[0] | lvl_any[1];
  assign gnt     = gnt_q;
  assign cpu_gnt = cpu_q;

  always_comb begin
    lvl_any = '0;
    for (int i = 0; i < NCH; i++)
      if (req[i]) lvl_any[prio[3*i +: 3]] = 1'b1;
    strict_lvl = 3'd0;
    for (int l = NLVL-1; l >= 0; l--)
      if (lvl_any[l]) strict_lvl = 3'(l);
  end

  always_comb begin
    int t;
    logic stop;
    t = 0;
    stop = 1'b0;
    for (int b = 0; b < SLOTW; b++) begin
      if (!stop && slot_q[b]) t++;
      else stop = 1'b1;
    end
    fav_ok  = (t < NLVL-2);
    fav_lvl = 3'(2 + t);
  end

  assign use_fav = fair_en && !urgent && fav_ok && lvl_any[fav_lvl];
  assign sel_lvl = use_fav ? fav_lvl : strict_lvl;

  always_comb begin
    int idx;
    pick_ok  = 1'b0;
    pick_idx = '0;
    for (int i = 0; i < NCH; i++)
      cand[i] = req[i] && (prio[3*i +: 3] == sel_lvl);
    for (int i = 0; i < NCH; i++)
      if (!pick_ok && cand[i] && !rr_en[i]) begin
        pick_ok  = 1'b1;
        pick_idx = IW'(i);
      end
    for (int k = 0; k < NCH; k++) begin
      idx = int'(ptr_q[sel_lvl]) + 1 + k;
      if (idx >= NCH) idx = idx - NCH;
      if (!pick_ok && cand[idx]) begin
        pick_ok  = 1'b1;
        pick_idx = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q  <= '0;
      cpu_q  <= 1'b0;
      slot_q <= '0;
      for (int l = 0; l < NLVL; l++) ptr_q[l] <= '0;
    end else if (arb) begin
      cpu_q <= cpu_req;
      gnt_q <= '0;
      if (!cpu_req && pick_ok) begin
        gnt_q[pick_idx] <= 1'b1;
        ptr_q[sel_lvl]  <= pick_idx;
      end
      if (fair_en && !urgent) slot_q <= slot_q + 1'b1;
    end
  end

  // R10
  one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gnt_q, cpu_q}));

  // R10
  grant_had_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb |=> ((gnt_q & ~$past(req)) == '0));

  // R2
  cpu_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb && cpu_req) |=> (cpu_q && gnt_q == '0));

  // R3
  hold_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer_done) |=> ($stable(gnt_q) && $stable(cpu_q)));

  // R11
  stay_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb && !cpu_req && req == '0) |=> !busy);
endmodule

// File: tb/dma_prio_arbiter_bench.sv
module dma_prio_arbiter_bench;
  localparam int NCH = 24;
  localparam int CPU = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] req = '0;
  logic [NCH-1:0] rr_en = '1;
  logic [2:0] pr [NCH];
  logic [3*NCH-1:0] prio;
  logic cpu_req = 1'b0, fair_en = 1'b0, xfer_done = 1'b0;
  logic [NCH-1:0] gnt;
  logic cpu_gnt;

  int total = 0, bad = 0;

  typedef struct { int exp; string tag; } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  always_comb
    for (int i = 0; i < NCH; i++) prio[3*i +: 3] = pr[i];

  dma_prio_arbiter u_dma_prio_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .prio(prio), .rr_en(rr_en),
    .cpu_req(cpu_req), .fair_en(fair_en), .xfer_done(xfer_done),
    .gnt(gnt), .cpu_gnt(cpu_gnt));

  function automatic int owner();
    int o, n;
    o = -1; n = 0;
    for (int i = 0; i < NCH; i++) if (gnt[i]) begin o = i; n++; end
    if (cpu_gnt) begin o = CPU; n++; end
    if (n > 1) o = -2;
    return o;
  endfunction

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      int act;
      it = q.pop_front();
      act = owner();
      total++;
      if (act != it.exp) begin
        bad++;
        $display("FAIL %s: owner=%0d expected=%0d", it.tag, act, it.exp);
      end
    end
  end

  task automatic step(input logic d, input int exp, input string tag);
    @(negedge clk);
    xfer_done = d;
    q.push_back('{exp, tag});
    @(posedge clk);
    #2;
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog: owner=%0d expected=done", owner());
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCH; i++) pr[i] = 3'd7;
    repeat (3) @(negedge clk);
    total++;
    if (gnt != '0 || cpu_gnt) begin
      bad++;
      $display("FAIL R1: owner=%0d expected=-1", owner());
    end
    rst_n = 1'b1;
    step(0, -1, "R1 idle after reset");
    req[3] = 1; pr[3] = 3'd4;
    step(0, 3, "R10 grant from idle");
    req[5] = 1; pr[5] = 3'd1;
    step(0, 3, "R3 hold while busy");
    step(1, 5, "R5 preempt at boundary");
    cpu_req = 1;
    step(0, 5, "R3 cpu waits for boundary");
    step(1, CPU, "R2 cpu wins");
    cpu_req = 0;
    step(1, 5, "R4 level 1 first");
    req[5] = 0;
    step(1, 3, "R4 remaining channel");
    req[8] = 1; pr[8] = 3'd4; req[10] = 1; pr[10] = 3'd4;
    step(1, 8, "R6 next above pointer");
    step(1, 10, "R6 rotate");
    step(1, 3, "R6 wrap");
    step(1, 8, "R6 rotate again");
    rr_en[10] = 0;
    step(1, 10, "R7 head of line");
    step(1, 10, "R7 stays at head");
    rr_en[8] = 0;
    step(1, 8, "R7 lowest head wins");
    rr_en = '1;
    req = '0;
    step(1, -1, "R11 idle after done");
    step(1, -1, "R11 done while idle");
    fair_en = 1;
    req[2] = 1; pr[2] = 3'd2; req[6] = 1; pr[6] = 3'd3;
    req[15] = 1; pr[15] = 3'd4; req[12] = 1; pr[12] = 3'd7;
    step(1, 2, "R8 slot0 level2");
    step(1, 6, "R8 slot1 level3");
    step(1, 2, "R8 slot2 level2");
    step(1, 15, "R8 slot3 level4");
    step(1, 2, "R8 slot4 level2");
    step(1, 6, "R8 slot5 level3");
    step(1, 2, "R8 slot6 level2");
    step(1, 2, "R8 slot7 empty fallback");
    req[20] = 1; pr[20] = 3'd0;
    step(1, 20, "R9 level0 bypass");
    step(1, 20, "R9 counter frozen");
    req[20] = 0;
    step(1, 2, "R9 slot8 level2");
    step(1, 6, "R9 slot9 level3");
    fair_en = 0;
    step(1, 2, "R4 strict with fairness off");
    step(1, 2, "R4 strict again");
    cpu_req = 1; req[20] = 1;
    step(1, CPU, "R2 cpu over level0");
    step(0, CPU, "R3 cpu holds");
    cpu_req = 0;
    step(1, 20, "R5 level0 after cpu");
    @(posedge clk); #2;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule